// File: doc/BRIEF.md
# Latched Interrupt Flag Aggregator

This block gathers a set of single-cycle event strobes from the surrounding peripheral logic. It holds each one in a sticky flag bit and merges the flags into one interrupt pulse for an external interrupt controller. A per-source enable mask chooses which flags may raise the interrupt. A flag still latches while its source is disabled, so a source that software enables later raises the interrupt at once.

A global interrupt flag sets together with each pulse. While it is set, no further pulse is sent. The service routine acknowledges through a write-one clear register, which clears the global flag and the serviced event flags. A write-one force register lets test software inject events as if the hardware had raised them. The default build has eleven sources, numbered 0 to 10.

Top module: `irq_flag_agg`

## Requirements
- R1: While reset is asserted and right after it is released, every event flag, the global flag, every enable bit and `irq_pulse` are 0.
- R2: A 1 on `evt_strobe[i]` sets event flag `flag_q[i]`, visible the cycle after the strobe, whatever the state of enable bit i.
- R3: A cycle with `en_wr` high loads `en_wdata` into the enable mask, readable on `en_q` the next cycle. The mask holds while `en_wr` is low.
- R4: When the global flag (`flag_q[NSRC]`) is 0 and some bit i has both `flag_q[i]` and `en_q[i]` at 1, `irq_pulse` is high for exactly one cycle. That cycle is the one after the condition appears, and the global flag reads 1 from that cycle on.
- R5: While the global flag is 1, `irq_pulse` stays 0, whatever new events arrive.
- R6: A cycle with `clr_wr` high clears every flag whose bit in `clr_wdata` is 1. Bit NSRC addresses the global flag and bits 0..NSRC-1 address the event flags. Flags whose `clr_wdata` bit is 0 keep their value.
- R7: A cycle with `frc_wr` high sets every event flag whose bit in `frc_wdata` is 1. A 0 bit leaves its flag unchanged.
- R8: When a strobe or force and a clear hit the same event flag in the same cycle, the flag ends up 1.
- R9: A flag latched while its source was disabled raises `irq_pulse` one cycle after its enable bit is written to 1, provided the global flag is 0.
- R10: If only the global flag is cleared while an enabled event flag stays set, another pulse follows. If both are cleared, no pulse occurs until a new event arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_strobe | input | NSRC | Single-cycle event strobes, one per source |
| en_wr | input | 1 | Write strobe for the enable mask |
| en_wdata | input | NSRC | Enable mask write data |
| en_q | output | NSRC | Current enable mask |
| clr_wr | input | 1 | Write strobe for the clear register |
| clr_wdata | input | NSRC+1 | Write-one-to-clear data; bit NSRC is the global flag |
| frc_wr | input | 1 | Write strobe for the force register |
| frc_wdata | input | NSRC | Write-one-to-set data for the event flags |
| flag_q | output | NSRC+1 | Event flags in bits 0..NSRC-1, global flag in bit NSRC |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
All state is visible on `flag_q` and `en_q` one cycle after the stimulus that changes it. A wrong flag or mask bit therefore shows up at the next sample. A wrong global flag shows up in `irq_pulse` within two cycles. It appears either as a second pulse without an acknowledgement or as a missing pulse after the acknowledgement re-arms the block. The bench counts pulses over windows of several cycles, so that both extra and missing pulses are caught, along with a pulse held longer than one cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  // Default number of event sources feeding the aggregator
  localparam int unsigned SRC_COUNT_DEF = 11;
endpackage

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int unsigned NSRC = irq_agg_pkg::SRC_COUNT_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] en_o
);
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] en_nxt;

  always_comb begin
    en_nxt = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_i) begin
      en_q <= en_nxt;
    end
  end

  assign en_o = en_q;

  // R3
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (en_o == $past(wdata_i)));

  // R3
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(en_o));
endmodule

// File: rtl/irq_evt_flags.sv
module irq_evt_flags #(
  parameter int unsigned NSRC = irq_agg_pkg::SRC_COUNT_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] set_sw_i,
  input  logic [NSRC-1:0] clr_sw_i,
  output logic [NSRC-1:0] flag_o
);
  logic [NSRC-1:0] flag_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic upd;
    logic nxt;

    // Set has priority over clear so no hardware event is lost
    always_comb begin
      upd = evt_i[i] | set_sw_i[i] | clr_sw_i[i];
      nxt = evt_i[i] | set_sw_i[i] | (flag_q[i] & ~clr_sw_i[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
      end else if (upd) begin
        flag_q[i] <= nxt;
      end
    end

    // R2 R7 R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i[i] || set_sw_i[i]) |=> flag_o[i]);

    // R6
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_sw_i[i] && !evt_i[i] && !set_sw_i[i]) |=> !flag_o[i]);

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[i] && !clr_sw_i[i]) |=> flag_o[i]);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic pending_i,
  input  logic gclr_i,
  output logic gflag_o,
  output logic pulse_o
);
  logic gflag_q;
  logic gflag_nxt;
  logic pulse_q;
  logic pulse_nxt;
  logic fire;

  always_comb begin
    fire      = pending_i & ~gflag_q;
    gflag_nxt = fire | (gflag_q & ~gclr_i);
    pulse_nxt = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gflag_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      gflag_q <= gflag_nxt;
      pulse_q <= pulse_nxt;
    end
  end

  assign gflag_o = gflag_q;
  assign pulse_o = pulse_q;

  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

  // R5
  gflag_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gflag_o |=> !pulse_o);

  // R4
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> $past(pending_i));
endmodule

// File: rtl/irq_flag_agg.sv
module irq_flag_agg #(
  parameter int unsigned NSRC = irq_agg_pkg::SRC_COUNT_DEF,
  localparam int unsigned FW  = NSRC + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_strobe,
  input  logic            en_wr,
  input  logic [NSRC-1:0] en_wdata,
  output logic [NSRC-1:0] en_q,
  input  logic            clr_wr,
  input  logic [FW-1:0]   clr_wdata,
  input  logic            frc_wr,
  input  logic [NSRC-1:0] frc_wdata,
  output logic [FW-1:0]   flag_q,
  output logic            irq_pulse
);
  localparam int unsigned GIDX = NSRC;

  logic [NSRC-1:0] set_sw;
  logic [NSRC-1:0] clr_sw;
  logic [NSRC-1:0] evt_flags;
  logic [NSRC-1:0] en_mask;
  logic            gclr;
  logic            pending;
  logic            gflag;

  always_comb begin
    set_sw  = frc_wr ? frc_wdata : '0;
    clr_sw  = clr_wr ? clr_wdata[NSRC-1:0] : '0;
    gclr    = clr_wr & clr_wdata[GIDX];
    pending = |(evt_flags & en_mask);
  end

  irq_en_reg #(.NSRC(NSRC)) en_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (en_wr),
    .wdata_i (en_wdata),
    .en_o    (en_mask)
  );

  irq_evt_flags #(.NSRC(NSRC)) flags_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_strobe),
    .set_sw_i (set_sw),
    .clr_sw_i (clr_sw),
    .flag_o   (evt_flags)
  );

  irq_pulse_gen pgen_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pending_i (pending),
    .gclr_i    (gclr),
    .gflag_o   (gflag),
    .pulse_o   (irq_pulse)
  );

  assign en_q   = en_mask;
  assign flag_q = {gflag, evt_flags};

  // R4
  pulse_sets_gflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> flag_q[GIDX]);

  // R9
  enable_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q[GIDX] && (|(flag_q[NSRC-1:0] & en_q))) |=> irq_pulse);
endmodule

// File: tb/irq_flag_agg_tb_top.sv
module irq_flag_agg_tb_top;
  localparam int unsigned NSRC = 11;
  localparam int unsigned FW   = NSRC + 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] evt_strobe = '0;
  logic            en_wr = 1'b0;
  logic [NSRC-1:0] en_wdata = '0;
  logic [NSRC-1:0] en_q;
  logic            clr_wr = 1'b0;
  logic [FW-1:0]   clr_wdata = '0;
  logic            frc_wr = 1'b0;
  logic [NSRC-1:0] frc_wdata = '0;
  logic [FW-1:0]   flag_q;
  logic            irq_pulse;

  int n_run  = 0;
  int n_fail = 0;
  int pcnt   = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_flag_agg #(.NSRC(NSRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe),
    .en_wr(en_wr), .en_wdata(en_wdata), .en_q(en_q),
    .clr_wr(clr_wr), .clr_wdata(clr_wdata),
    .frc_wr(frc_wr), .frc_wdata(frc_wdata),
    .flag_q(flag_q), .irq_pulse(irq_pulse)
  );

  // Counts pulses seen during the cycle before each rising edge
  always @(posedge clk) if (rst_n && irq_pulse) pcnt <= pcnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic strobe(input logic [NSRC-1:0] m);
    evt_strobe = m; tick(); evt_strobe = '0;
  endtask

  task automatic wr_en(input logic [NSRC-1:0] m);
    en_wr = 1'b1; en_wdata = m; tick(); en_wr = 1'b0;
  endtask

  task automatic wr_clr(input logic [FW-1:0] m);
    clr_wr = 1'b1; clr_wdata = m; tick(); clr_wr = 1'b0; clr_wdata = '0;
  endtask

  task automatic wr_frc(input logic [NSRC-1:0] m);
    frc_wr = 1'b1; frc_wdata = m; tick(); frc_wr = 1'b0; frc_wdata = '0;
  endtask

  task automatic cleanup();
    wr_en('0);
    wr_clr('1);
    tick(2);
    pcnt = 0;
  endtask

  task automatic t_reset();
    tick(3);
    chk("R1 flags in reset", 32'(flag_q), 0);
    chk("R1 enables in reset", 32'(en_q), 0);
    chk("R1 pulse in reset", 32'(irq_pulse), 0);
    rst_n = 1'b1;
    tick();
    chk("R1 flags after release", 32'(flag_q), 0);
    chk("R1 enables after release", 32'(en_q), 0);
  endtask

  task automatic t_enable();
    cleanup();
    wr_en(11'h2A5);
    chk("R3 enable load A", 32'(en_q), 32'h2A5);
    tick(2);
    chk("R3 enable hold", 32'(en_q), 32'h2A5);
    wr_en(11'h15A);
    chk("R3 enable load B", 32'(en_q), 32'h15A);
  endtask

  task automatic t_latch_disabled();
    cleanup();
    strobe(11'h084);
    chk("R2 latch while disabled", 32'(flag_q), 32'h084);
    tick(3);
    chk("R9 no pulse while disabled", 32'(pcnt), 0);
    wr_en(11'h080);
    chk("R9 pulse not yet", 32'(irq_pulse), 0);
    tick();
    chk("R9 pulse after enable", 32'(irq_pulse), 1);
    chk("R9 global flag set", 32'(flag_q[NSRC]), 1);
  endtask

  task automatic t_pulse();
    cleanup();
    wr_en(11'h008);
    strobe(11'h008);
    chk("R4 no pulse same cycle as flag", 32'(irq_pulse), 0);
    tick();
    chk("R4 pulse high", 32'(irq_pulse), 1);
    chk("R4 global flag with pulse", 32'(flag_q[NSRC]), 1);
    tick();
    chk("R4 pulse one cycle", 32'(irq_pulse), 0);
    strobe(11'h008);
    wr_en(11'h7FF);
    strobe(11'h020);
    tick(4);
    chk("R5 blocked while global set", 32'(pcnt), 1);
  endtask

  task automatic t_clear();
    cleanup();
    wr_frc('1);
    wr_clr(12'h00F);
    chk("R6 partial clear", 32'(flag_q), 32'h7F0);
    wr_clr(12'h000);
    chk("R6 zero clear no effect", 32'(flag_q), 32'h7F0);
    wr_clr(12'h7F0);
    chk("R6 clear rest", 32'(flag_q), 0);
  endtask

  task automatic t_force();
    cleanup();
    wr_frc(11'h401);
    chk("R7 force sets", 32'(flag_q), 32'h401);
    wr_frc(11'h000);
    chk("R7 zero force no effect", 32'(flag_q), 32'h401);
    tick(2);
    chk("R7 forced flags no pulse disabled", 32'(pcnt), 0);
  endtask

  task automatic t_setwins();
    cleanup();
    wr_frc(11'h010);
    evt_strobe = 11'h050; clr_wr = 1'b1; clr_wdata = 12'h050;
    tick();
    evt_strobe = '0; clr_wr = 1'b0; clr_wdata = '0;
    chk("R8 set beats clear", 32'(flag_q), 32'h050);
    frc_wr = 1'b1; frc_wdata = 11'h002; clr_wr = 1'b1; clr_wdata = 12'h052;
    tick();
    frc_wr = 1'b0; frc_wdata = '0; clr_wr = 1'b0; clr_wdata = '0;
    chk("R8 force beats clear", 32'(flag_q), 32'h002);
  endtask

  task automatic t_rearm();
    cleanup();
    wr_en(11'h002);
    strobe(11'h002);
    tick(3);
    chk("R10 first pulse", 32'(pcnt), 1);
    wr_clr(12'h800);
    tick(3);
    chk("R10 refire after global-only clear", 32'(pcnt), 2);
    chk("R10 global set again", 32'(flag_q[NSRC]), 1);
    wr_clr(12'h802);
    tick(3);
    chk("R10 no pulse after full clear", 32'(pcnt), 2);
    chk("R6 global and event cleared", 32'(flag_q), 0);
    strobe(11'h002);
    tick(3);
    chk("R10 pulse on new event", 32'(pcnt), 3);
  endtask

  initial begin
    t_reset();
    t_enable();
    t_latch_disabled();
    t_pulse();
    t_clear();
    t_force();
    t_setwins();
    t_rearm();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule